// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache with Parked Eviction

This block is a direct-mapped data cache for 32-bit byte addresses. It holds 4-byte lines and serves a processor from a tag, valid and dirty store. Writes allocate on a miss and are kept local until the line is displaced. A miss stalls the processor while a small controller fetches the line from the next memory level.

When the line being displaced is dirty, the block does not send it out first. It copies the old line into a one-entry eviction buffer and issues the line read for the missing address at once. After the new line is installed, the processor continues and the parked line is written to the next level in the background. Any later miss waits until that write has been answered. Because of this, the next level never sees a read for a line whose newest value is still in the buffer.

The processor holds `req_valid` and its request fields stable until the cycle in which `req_ready` is high. The access completes at that clock edge, and `req_rdata` is valid in that same cycle. The next-level port carries one transaction at a time. `mem_req` and its fields stay stable until the cycle in which `mem_rvalid` is high, which completes the transaction.

Top module: `wb_cache`

## Requirements
- R1: Address bits [11:2] select one of 1024 lines and bits [31:12] form the stored tag. Bits [1:0] do not affect hit or miss. An access hits only when the line is valid and its tag equals the address tag, so two addresses with the same index and different tags displace each other.
- R2: On a read hit, `req_ready` is high in the same cycle as the request and `req_rdata` carries the whole 32-bit line.
- R3: On a write hit, each byte lane b whose enable `req_be[b]` is 1 takes `req_wdata[8b+7:8b]`, the other lanes keep their value, and the line becomes dirty.
- R4: On a miss, `req_ready` stays low. From the next cycle the block holds a line read on the memory port (`mem_req`=1, `mem_we`=0, `mem_addr` = the line address with bits [1:0] zero) until `mem_rvalid`. It then installs `mem_rdata` with the new tag, and the stalled access completes one cycle after the response.
- R5: A write miss first fills the line from the next level and then applies the byte-enabled write to the filled data.
- R6: When a dirty line is displaced, the line read for the new address goes out first. The displaced line is written to its own line address with its latest data only after that fill has completed. A clean or invalid victim produces no write.
- R7: A line that was filled and never written is clean and produces no memory write when it is displaced.
- R8: While the eviction buffer holds a line, hits continue to complete, but no new miss starts until the buffer's write has been answered.
- R9: A read of the line that sits in the eviction buffer returns its latest written value and never an older copy.
- R10: During reset `req_ready` is low. After reset every line is invalid, so the first access misses, and the eviction buffer is empty, so `mem_req` stays low until a miss occurs.
- R11: The memory port has at most one outstanding transaction. Once `mem_req` is high, it stays high with the same `mem_addr` and `mem_we` until `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor access present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, bit b for lane b |
| req_ready | output | 1 | Access completes at this edge |
| req_rdata | output | 32 | Read data, valid when `req_ready` is high |
| mem_req | output | 1 | Next-level transaction pending |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | 32 | Line address, bits [1:0] zero |
| mem_wdata | output | 32 | Line data for a write |
| mem_rvalid | input | 1 | Transaction completes at this edge |
| mem_rdata | input | 32 | Line data for a read |

## Verification
A hit is due in the cycle it is presented, so the bench samples `req_ready` and `req_rdata` shortly after the falling edge of the request cycle. A miss is due one cycle after the memory response. Its fill read appears on the memory port one cycle after the miss, and the displaced line's write appears one cycle after the fill response. The bench therefore waits for `req_ready` at each falling edge and counts the stalled cycles. It records the memory transactions in the order they are first seen and checks that order only after enough idle cycles for the background write to finish. Write-back data is compared at the moment the write appears against a reference image that the bench updates as each processor write completes.

// File: rtl/wb_cache.sv
module wb_cache #(
  parameter int IDX_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_we,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [3:0]  req_be,
  output logic        req_ready,
  output logic [31:0] req_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = 30 - IDX_W;

  logic [TAG_W-1:0] tag_q  [LINES];
  logic [31:0]      data_q [LINES];
  logic [LINES-1:0] valid_q, dirty_q;
  logic             fill_q, wbb_valid_q;
  logic [29:0]      miss_line_q, wbb_line_q;
  logic [31:0]      wbb_data_q, merged;

  wire [IDX_W-1:0] idx      = req_addr[IDX_W+1:2];
  wire [TAG_W-1:0] tag      = req_addr[31:IDX_W+2];
  wire [IDX_W-1:0] miss_idx = miss_line_q[IDX_W-1:0];
  wire             hit      = valid_q[idx] && (tag_q[idx] == tag);
  wire             start_miss = rst_n && req_valid && !hit && !fill_q && !wbb_valid_q;
  wire             fill_done  = fill_q && mem_rvalid;
  wire             drain_done = !fill_q && wbb_valid_q && mem_rvalid;
  wire             unused_ofs = &{1'b0, req_addr[1:0]};

  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign merged[8*b +: 8] = req_be[b] ? req_wdata[8*b +: 8] : data_q[idx][8*b +: 8];
  end

  assign req_ready = rst_n && req_valid && hit && !fill_q;
  assign req_rdata = data_q[idx];
  assign mem_req   = fill_q || wbb_valid_q;
  assign mem_we    = !fill_q && wbb_valid_q;
  assign mem_addr  = {fill_q ? miss_line_q : wbb_line_q, 2'b00};
  assign mem_wdata = wbb_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q      <= 1'b0;
      wbb_valid_q <= 1'b0;
      valid_q     <= '0;
      dirty_q     <= '0;
      miss_line_q <= '0;
      wbb_line_q  <= '0;
      wbb_data_q  <= '0;
    end else begin
      if (start_miss) begin
        fill_q      <= 1'b1;
        miss_line_q <= req_addr[31:2];
        if (valid_q[idx] && dirty_q[idx]) begin
          wbb_valid_q <= 1'b1;
          wbb_line_q  <= {tag_q[idx], idx};
          wbb_data_q  <= data_q[idx];
        end
      end
      if (fill_done) begin
        fill_q            <= 1'b0;
        valid_q[miss_idx] <= 1'b1;
        dirty_q[miss_idx] <= 1'b0;
      end
      if (drain_done) wbb_valid_q <= 1'b0;
      if (req_ready && req_we) dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done) begin
      data_q[miss_idx] <= mem_rdata;
      tag_q[miss_idx]  <= miss_line_q[29:IDX_W];
    end
    if (req_ready && req_we) data_q[idx] <= merged;
  end
endmodule

// File: rtl/wb_cache_chk.sv
module wb_cache_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic        fill_q,
  input logic        wbb_valid_q
);
  assert_ready_low_in_reset_R10: assert property (@(posedge clk)
    !rst_n |-> !req_ready);

  assert_txn_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_stall_during_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q |-> !req_ready);

  assert_fill_ends_on_response_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q && mem_rvalid |=> !fill_q);

  assert_drain_follows_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q && mem_rvalid && wbb_valid_q |=> mem_req && mem_we);

  assert_miss_waits_for_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && wbb_valid_q && !fill_q |=> !fill_q);
endmodule

bind wb_cache wb_cache_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
  .fill_q(fill_q), .wbb_valid_q(wbb_valid_q)
);

// File: tb/wb_cache_tb_top.sv
`timescale 1ns/1ps
module wb_cache_tb_top;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [3:0] req_be = 0;
  logic req_ready;
  logic [31:0] req_rdata;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;

  wb_cache dut_i (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, stab_err = 0, lat_fixed = 2;
  logic [31:0] ref_m [logic [29:0]];
  logic [31:0] mem_m [logic [29:0]];
  bit   log_we [64];
  logic [29:0] log_line [64];
  int log_n = 0;

  function automatic logic [31:0] init_val(logic [29:0] l);
    return {l, 2'b00} ^ 32'hC3A5_0F1E;
  endfunction
  function automatic logic [31:0] ref_rd(logic [29:0] l);
    return ref_m.exists(l) ? ref_m[l] : init_val(l);
  endfunction
  function automatic logic [31:0] mem_rd(logic [29:0] l);
    return mem_m.exists(l) ? mem_m[l] : init_val(l);
  endfunction
  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // next-level memory model
  initial begin
    bit busy = 0;
    int cnt = 0;
    logic [29:0] l_line;
    bit l_we;
    logic [31:0] l_wd;
    forever begin
      @(negedge clk);
      mem_rvalid = 0;
      if (!rst_n) busy = 0;
      else begin
        if (!busy && mem_req) begin
          busy = 1;
          l_line = mem_addr[31:2];
          l_we = mem_we;
          l_wd = mem_wdata;
          cnt = (lat_fixed >= 0) ? lat_fixed : $urandom_range(0, 3);
          if (mem_addr[1:0] != 2'b00) stab_err++;
          if (log_n < 64) begin log_we[log_n] = l_we; log_line[log_n] = l_line; end
          log_n++;
          if (l_we) chk(l_wd == ref_rd(l_line), "R6 write-back data", l_wd, ref_rd(l_line));
        end else if (busy) begin
          if (!mem_req || mem_addr[31:2] != l_line || mem_we != l_we) stab_err++;
        end
        if (busy) begin
          if (cnt == 0) begin
            mem_rvalid = 1;
            busy = 0;
            if (l_we) mem_m[l_line] = l_wd;
            else mem_rdata = mem_rd(l_line);
          end else cnt--;
        end
      end
    end
  end

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input string tag, output int stalls);
    logic [31:0] rd, exp;
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = wd; req_be = be;
    stalls = 0;
    forever begin
      #1;
      if (req_ready) break;
      stalls++;
      if (stalls > 400) break;
      @(negedge clk);
    end
    if (stalls > 400) chk(0, {tag, " access hung"}, 0, 1);
    else begin
      rd = req_rdata;
      exp = ref_rd(a[31:2]);
      if (!we) chk(rd == exp, tag, rd, exp);
      else ref_m[a[31:2]] = merge(exp, wd, be);
    end
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int st;
    logic [31:0] A, B, C, D;
    A = 32'h0000_1014; B = 32'h0000_2014; C = 32'h0000_3028; D = 32'h0000_3014;
    void'($urandom(32'd1234));
    req_valid = 1; req_addr = A;
    repeat (3) @(negedge clk);
    chk(req_ready == 0, "R10 ready low in reset", {31'b0, req_ready}, 0);
    rst_n = 1; req_valid = 0;
    idle(3);
    chk(mem_req == 0, "R10 no memory request after reset", {31'b0, mem_req}, 0);

    log_n = 0;
    access(0, A, 0, 0, "R10 first read after reset", st);
    chk(st > 0, "R10/R4 first access misses", st, 1);
    chk(log_n == 1 && !log_we[0] && log_line[0] == A[31:2], "R4 single line read",
        {log_line[0], 2'b0}, A);
    access(0, A + 3, 0, 0, "R2 read hit", st);
    chk(st == 0, "R1 offset bits ignored for hit", st, 0);
    access(1, A, 32'hAABB_CCDD, 4'b0101, "R3", st);
    chk(st == 0, "R3 write hit no stall", st, 0);
    access(0, A, 0, 0, "R3 merged bytes read back", st);

    log_n = 0;
    access(1, C, 32'h1122_3344, 4'b0011, "R5", st);
    chk(log_n == 1 && !log_we[0] && log_line[0] == C[31:2], "R5 write miss fills", log_n, 1);
    access(0, C, 0, 0, "R5 allocated line merged", st);

    log_n = 0;
    access(0, B, 0, 0, "R1 same index new tag", st);
    chk(st > 0, "R1 conflicting tag misses", st, 1);
    idle(12);
    chk(log_n == 2 && !log_we[0] && log_line[0] == B[31:2], "R6 fill read first",
        {log_line[0], 2'b0}, B);
    chk(log_we[1] && log_line[1] == A[31:2], "R6 victim written after fill",
        {log_line[1], 2'b0}, A);

    log_n = 0;
    access(0, D, 0, 0, "R7 read over clean line", st);
    idle(12);
    chk(log_n == 1, "R7 clean victim not written", log_n, 1);

    access(1, A, 32'h5566_7788, 4'b1111, "R9 setup write", st);
    log_n = 0;
    access(0, B, 0, 0, "R8 evicting read", st);
    access(0, B, 0, 0, "R8 hit during drain", st);
    chk(st == 0, "R8 hit completes while buffer full", st, 0);
    access(0, A, 0, 0, "R9 read of parked line", st);
    idle(12);
    chk(log_n == 3 && log_we[1] && !log_we[2] && log_line[2] == A[31:2],
        "R8 miss waits for drain", log_n, 3);

    lat_fixed = -1;
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] ad;
      ad = ({$urandom_range(0, 3)} << 12) | ({$urandom_range(0, 3)} << 2) | {$urandom_range(0, 3)};
      if ($urandom_range(0, 2) == 0)
        access(1, ad, $urandom, 4'($urandom_range(0, 15)), "R3 random write", st);
      else
        access(0, ad, 0, 0, "R2 random read", st);
      if ($urandom_range(0, 9) == 0) idle($urandom_range(1, 6));
    end
    idle(20);
    chk(stab_err == 0, "R11 request held stable until response", stab_err, 0);
    finish_run();
  end
endmodule